// File: doc/BRIEF.md
# Configuration Image Reload Supervisor

This block sits next to an FPGA and the memory that holds its configuration images, and forces the FPGA to reload from a chosen image. Two requesters can ask for a reload: the application running in the FPGA and a host command port. Each requester has its own code bus and a one-cycle go strobe. When a strobe is accepted, the code is captured in a holding register and drives the memory's image-select outputs. The FPGA's program line is then pulled low and later released. After that the block waits for the FPGA to report that configuration has finished.

The holding register is inside this block, so the selection remains valid while the FPGA loses all its state and its pins fall back to defaults. The memory reads the select lines when the program line rises. For this reason the code is driven before the program line goes low, kept for a settling interval before the release, and held unchanged after it. At reset the outputs carry a default image code. Status outputs report busy, successful completion and a timeout error.

Top module: `cfg_rev_sel`

## Requirements
- R1: While reset is asserted and right after it is released, `rev_sel_o` equals parameter `DEFAULT_SEL`, `prog_n_o` is 1 and `busy_o`, `done_o` and `err_o` are 0.
- R2: If `app_go_i` is high while the block is idle, `app_sel_i` appears on `rev_sel_o` at the next clock edge and `busy_o` rises at that same edge.
- R3: A strobe on `host_go_i` while idle behaves the same way and loads `host_sel_i`.
- R4: If both strobes are high in the same idle cycle, the host code is loaded.
- R5: `prog_n_o` goes low one cycle after the code is latched and stays low for exactly `PROG_LOW_CYC + SETUP_CYC` cycles. Of these, the last `SETUP_CYC` cycles are the settling interval before the release.
- R6: `rev_sel_o` does not change while `busy_o` is high, which includes the release edge of `prog_n_o` and the cycles after it.
- R7: `prog_n_o` is low only while `busy_o` is high.
- R8: If `cfg_done_i` is high in a wait cycle after the release, `done_o` is set and the block returns to idle. Both `done_o` and `err_o` are cleared when the next request is accepted.
- R9: If `cfg_done_i` stays low for `DONE_TIMEOUT` wait cycles, `err_o` is set, `done_o` stays 0 and the block returns to idle. In that case `busy_o` is high for exactly `2 + PROG_LOW_CYC + SETUP_CYC + DONE_TIMEOUT` cycles.
- R10: Strobes from either port that arrive while `busy_o` is high have no effect. They start no later sequence and do not change `rev_sel_o`.
- R11: `done_o` and `err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| app_sel_i | input | SEL_W | Image code from the application |
| app_go_i | input | 1 | Application reload strobe |
| host_sel_i | input | SEL_W | Image code from the host port |
| host_go_i | input | 1 | Host reload strobe |
| cfg_done_i | input | 1 | FPGA configuration-finished flag |
| rev_sel_o | output | SEL_W | Held image-select lines to the memory |
| prog_n_o | output | 1 | FPGA program line, active low |
| busy_o | output | 1 | Reload sequence in progress |
| done_o | output | 1 | Last reload finished successfully |
| err_o | output | 1 | Last reload timed out |

## Verification
The assertions assume that reset is held for at least one clock edge, so that every registered output has a known value before the first sampled cycle. The duration check on the program pulse also assumes that both timing parameters are at least one. The bench drives its strobes at the falling edge, holds each strobe for exactly one cycle and only changes the code buses at that time. It models the FPGA's done flag as low while the program line is low and rising a set delay after the release, with a zero delay standing for a device that never finishes. It sweeps every code value through both ports.

// File: rtl/cfg_rev_pkg.sv
package cfg_rev_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LATCH   = 3'd1,
    ST_PLOW    = 3'd2,
    ST_SETTLE  = 3'd3,
    ST_RELEASE = 3'd4,
    ST_WAITD   = 3'd5
  } seq_state_t;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cfg_req_arb.sv
module cfg_req_arb #(
  parameter int unsigned SEL_W = 2
) (
  input  logic [SEL_W-1:0] app_sel_i,
  input  logic             app_go_i,
  input  logic [SEL_W-1:0] host_sel_i,
  input  logic             host_go_i,
  output logic             req_go_o,
  output logic [SEL_W-1:0] req_sel_o
);

  // host port wins a same-cycle collision
  always_comb begin
    req_go_o  = app_go_i | host_go_i;
    req_sel_o = host_go_i ? host_sel_i : app_sel_i;
  end

endmodule

// File: rtl/cfg_sel_hold.sv
module cfg_sel_hold #(
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned DEFAULT_SEL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en_i,
  input  logic [SEL_W-1:0] load_val_i,
  output logic [SEL_W-1:0] sel_o
);

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_d;

  always_comb begin
    sel_d = sel_q;
    if (load_en_i) sel_d = load_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= SEL_W'(DEFAULT_SEL);
    else        sel_q <= sel_d;
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_rev_pkg::*;
#(
  parameter int unsigned PROG_LOW_CYC = 8,
  parameter int unsigned SETUP_CYC    = 4,
  parameter int unsigned DONE_TIMEOUT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_go_i,
  input  logic cfg_done_i,
  output logic load_en_o,
  output logic prog_n_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);

  localparam int unsigned MAXC  = max3(PROG_LOW_CYC, SETUP_CYC, DONE_TIMEOUT);
  localparam int unsigned CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             set_done, set_err;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    load_en_o = 1'b0;
    set_done  = 1'b0;
    set_err   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_go_i) begin
          load_en_o = 1'b1;
          state_d   = ST_LATCH;
        end
      end
      ST_LATCH:   state_d = ST_PLOW;
      ST_PLOW: begin
        if (cnt_q == CNT_W'(PROG_LOW_CYC - 1)) state_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (cnt_q == CNT_W'(SETUP_CYC - 1)) state_d = ST_RELEASE;
      end
      ST_RELEASE: state_d = ST_WAITD;
      ST_WAITD: begin
        if (cfg_done_i) begin
          set_done = 1'b1;
          state_d  = ST_IDLE;
        end else if (cnt_q == CNT_W'(DONE_TIMEOUT - 1)) begin
          set_err = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // interval counter restarts on every state change
  always_comb begin
    if (state_d != state_q) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  // sticky status, cleared by an accepted request
  always_comb begin
    done_d = done_q;
    err_d  = err_q;
    if (load_en_o) begin
      done_d = 1'b0;
      err_d  = 1'b0;
    end
    if (set_done) done_d = 1'b1;
    if (set_err)  err_d  = 1'b1;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign prog_n_o = !((state_q == ST_PLOW) || (state_q == ST_SETTLE));
  assign done_o   = done_q;
  assign err_o    = err_q;

endmodule

// File: rtl/cfg_rev_sel.sv
module cfg_rev_sel #(
  parameter int unsigned SEL_W        = 2,
  parameter int unsigned DEFAULT_SEL  = 0,
  parameter int unsigned PROG_LOW_CYC = 8,
  parameter int unsigned SETUP_CYC    = 4,
  parameter int unsigned DONE_TIMEOUT = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] app_sel_i,
  input  logic             app_go_i,
  input  logic [SEL_W-1:0] host_sel_i,
  input  logic             host_go_i,
  input  logic             cfg_done_i,
  output logic [SEL_W-1:0] rev_sel_o,
  output logic             prog_n_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);

  logic             req_go;
  logic [SEL_W-1:0] req_sel;
  logic             load_en;

  cfg_req_arb #(.SEL_W(SEL_W)) arb_i (
    .app_sel_i  (app_sel_i),
    .app_go_i   (app_go_i),
    .host_sel_i (host_sel_i),
    .host_go_i  (host_go_i),
    .req_go_o   (req_go),
    .req_sel_o  (req_sel)
  );

  cfg_seq_fsm #(
    .PROG_LOW_CYC (PROG_LOW_CYC),
    .SETUP_CYC    (SETUP_CYC),
    .DONE_TIMEOUT (DONE_TIMEOUT)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_go_i   (req_go),
    .cfg_done_i (cfg_done_i),
    .load_en_o  (load_en),
    .prog_n_o   (prog_n_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  cfg_sel_hold #(.SEL_W(SEL_W), .DEFAULT_SEL(DEFAULT_SEL)) hold_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en_i  (load_en),
    .load_val_i (req_sel),
    .sel_o      (rev_sel_o)
  );

endmodule

// File: rtl/cfg_rev_sel_chk.sv
module cfg_rev_sel_chk #(
  parameter int unsigned SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] rev_sel_o,
  input logic             prog_n_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o
);

  assert_sel_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(rev_sel_o));

  assert_release_settled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_n_o) |-> (busy_o && $stable(rev_sel_o)));

  assert_prog_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> busy_o);

  assert_pulse_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_n_o) |=> !prog_n_o);

  assert_status_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  assert_status_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !busy_o);

endmodule

bind cfg_rev_sel cfg_rev_sel_chk #(.SEL_W(SEL_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rev_sel_o (rev_sel_o),
  .prog_n_o  (prog_n_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o)
);

// File: tb/cfg_rev_sel_tb_top.sv
`timescale 1ns/1ps
module cfg_rev_sel_tb_top;

  localparam int SW  = 2;
  localparam int DEF = 2;
  localparam int P   = 3;
  localparam int S   = 2;
  localparam int T   = 20;

  logic          clk;
  logic          rst_n;
  logic [SW-1:0] app_sel, host_sel;
  logic          app_go, host_go;
  logic          cfg_done;
  logic [SW-1:0] rev_sel;
  logic          prog_n, busy, done, err;

  int total = 0;
  int bad   = 0;
  int dly   = 5;
  int dcnt  = 0;
  int cyc   = 0;

  cfg_rev_sel #(
    .SEL_W(SW), .DEFAULT_SEL(DEF), .PROG_LOW_CYC(P),
    .SETUP_CYC(S), .DONE_TIMEOUT(T)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .app_sel_i(app_sel), .app_go_i(app_go),
    .host_sel_i(host_sel), .host_go_i(host_go),
    .cfg_done_i(cfg_done),
    .rev_sel_o(rev_sel), .prog_n_o(prog_n),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // FPGA model: done low while program is low, rises dly cycles after release
  always @(negedge clk) begin
    if (!prog_n) begin
      cfg_done <= 1'b0;
      dcnt     <= 0;
    end else if (!cfg_done && dly != 0) begin
      if (dcnt == dly - 1) cfg_done <= 1'b1;
      else                 dcnt     <= dcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // port: 0 app, 1 host, 2 both (host code = code, app code = ~code)
  task automatic request(input int port, input int code, input int exp_code,
                         input bit ghost, input bit expect_err);
    int lows;
    int blen;
    @(negedge clk);
    app_sel  = (port == 2) ? SW'(~code) : SW'(code);
    host_sel = SW'(code);
    app_go   = (port != 1);
    host_go  = (port != 0);
    @(negedge clk);
    app_go  = 1'b0;
    host_go = 1'b0;
    chk(rev_sel == SW'(exp_code), (port == 1) ? "R3 code" : (port == 2) ? "R4 prio" : "R2 code",
        int'(rev_sel), exp_code);
    chk(busy == 1'b1, "R2 busy", int'(busy), 1);
    chk(prog_n == 1'b1, "R5 latch cycle", int'(prog_n), 1);
    chk(!done && !err, "R8 clear", int'({done, err}), 0);
    blen = 1;
    lows = 0;
    while (busy && blen < 200) begin
      if (ghost && blen == 2) begin
        app_sel = SW'(~exp_code); host_sel = SW'(~exp_code);
        app_go = 1'b1; host_go = 1'b1;
      end
      @(negedge clk);
      app_go = 1'b0; host_go = 1'b0;
      if (!prog_n) lows++;
      if (busy) begin
        blen++;
        if (rev_sel != SW'(exp_code)) chk(1'b0, "R6 held", int'(rev_sel), exp_code);
      end
    end
    chk(lows == P + S, "R5 low len", lows, P + S);
    if (expect_err) begin
      chk(err && !done, "R9 err", int'({done, err}), 1);
      chk(blen == 2 + P + S + T, "R9 busy len", blen, 2 + P + S + T);
    end else begin
      chk(done && !err, "R8 done", int'({done, err}), 2);
    end
    repeat (3) @(negedge clk);
    chk(!busy && rev_sel == SW'(exp_code), "R10 idle", int'(busy), 0);
  endtask

  initial begin
    rst_n = 1'b0; app_go = 1'b0; host_go = 1'b0;
    app_sel = '0; host_sel = '0;
    repeat (3) @(negedge clk);
    chk(rev_sel == SW'(DEF) && prog_n && !busy && !done && !err, "R1 in reset",
        int'(rev_sel), DEF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(rev_sel == SW'(DEF) && prog_n && !busy && !done && !err, "R1 after reset",
        int'(rev_sel), DEF);
    // R2 R3: sweep all codes on both ports
    for (int port = 0; port < 2; port++)
      for (int c = 0; c < (1 << SW); c++)
        request(port, c, c, 1'b0, 1'b0);
    // R4: simultaneous strobes
    for (int c = 0; c < (1 << SW); c++) request(2, c, c, 1'b0, 1'b0);
    // R10: strobes during busy ignored
    request(0, 1, 1, 1'b1, 1'b0);
    request(1, 2, 2, 1'b1, 1'b0);
    // R9: timeout, then recovery clears error (R8)
    dly = 0;
    request(0, 3, 3, 1'b0, 1'b1);
    dly = 7;
    request(1, 0, 0, 1'b0, 1'b0);
    dly = 1;
    request(0, 2, 2, 1'b0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule